// File: doc/BRIEF.md
# Space-Shift Duplicated Band Systolic Array

This block computes one row of a band matrix-vector product per accepted beat. Each beat carries the row's band coefficients and the matching vector elements. A linear chain of processing elements works through them, one multiply-accumulate per element. The partial sum moves one element further on each clock. New beats enter at most every second cycle. Each element is therefore busy in one cycle and idle in the next.

The idle slot is used for concurrent error detection. In the same cycle that element k does its own multiply-accumulate, element k+1 is idle. Element k+1 recomputes the same operation from the same operands. A comparator matches the two results. The last element's work is repeated by a single spare element at the end of the chain, so the hardware overhead is one element rather than a second array. A mismatch flags the result that passed through that stage and sets a sticky error bit. Under a single-fault assumption this exposes a permanent fault in any one element.

The input side is valid/ready. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold its beat. `in_ready` drops for exactly one cycle after every accepted beat. This enforces the two-cycle pipeline period. The output side has no back-pressure: the consumer must take each result in the one cycle that `out_valid` is high.

For fault experiments, the parameter `STUCK_PE` selects one element (0 to BAND, where BAND is the spare) whose result bit `STUCK_BIT` is held at 1. The default of -1 selects no element.

Top module: `sysdup_array`

## Requirements
- R1: A beat is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low during the cycle after each accepted beat and high in every other cycle.
- R2: For each accepted beat, `out_y` equals the sum over k of coef_k times x_k, taken modulo 2^32. Here coef_k is `in_coef[16k+15:16k]` and x_k is `in_x[16k+15:16k]`, both signed two's complement. Lane k=0 is the lowest lane. `out_first` repeats the beat's `in_first`.
- R3: `out_valid` is high for one cycle per accepted beat. That cycle begins at the BAND-1'th (second, by default) rising edge after the accepting edge. With `in_valid` held high, one beat is accepted and one result appears every second cycle.
- R4: No element is asked to do its own work and a duplicate computation in the same cycle. A fault-free design streaming at full rate raises no error flag.
- R5: Each element's result is recomputed in the same cycle by the next element. The last element's result is recomputed by the spare. Any mismatch sets `out_err` on the result that went through that stage. With a stuck-at-1 bit in element 1, every result whose true partial sums have that bit clear comes out with `out_err` = 1 and `out_y` raised by 2^STUCK_BIT.
- R6: In a fault-free design, `out_err` and `err_sticky` stay 0.
- R7: `err_sticky` is set in the cycle after any comparator mismatch. It stays set until reset.
- R8: After reset, `in_ready` is 1, `out_valid` is 0 and `err_sticky` is 0.
- R9: A fault in the spare element raises `out_err`, but `out_y` is still correct.
- R10: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Array can take a beat on this edge |
| in_first | input | 1 | Marks the first row of a vector; passed through to `out_first` |
| in_coef | input | BAND*DW (48) | Band coefficients of the row, lane k in bits 16k+15:16k |
| in_x | input | BAND*DW (48) | Vector elements paired with each coefficient lane |
| out_valid | output | 1 | Result strobe, one cycle per row |
| out_first | output | 1 | Copy of `in_first` for this result |
| out_y | output | AW (32) | Row result |
| out_err | output | 1 | A duplicate comparison for this row mismatched |
| err_sticky | output | 1 | Some mismatch has occurred since reset |

## Verification
The bench holds `in_valid` high so that beats arrive at the full two-cycle rate. A schedule that let an element be asked for both its own and its neighbour's work in one cycle would then corrupt results or raise false flags on a clean array. It checks the ready gap after each accept and the exact output cycle: an extra or missing pipeline register would shift results by a cycle. It also uses signed extremes whose sum wraps, which catches a product that is not sign-extended. Two fault-injected copies run next to the clean one. In the first, a stuck bit in a middle element must both corrupt `out_y` by the stuck weight and raise the flag. In the second, a stuck bit in the spare must raise the flag while `out_y` stays exact. The sticky bit is watched through idle cycles and then cleared by reset.

// File: rtl/sysdup_pkg.sv
package sysdup_pkg;
  // Operand source chosen by a processing element in a given cycle
  typedef enum logic [1:0] {
    PE_IDLE = 2'd0,
    PE_OWN  = 2'd1,
    PE_DUP  = 2'd2
  } pe_sel_e;
endpackage

// File: rtl/sysdup_pe.sv
module sysdup_pe
  import sysdup_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 32,
  parameter bit STUCK_EN  = 1'b0,
  parameter int STUCK_BIT = 0
) (
  input  logic          own_v,
  input  logic [AW-1:0] own_acc,
  input  logic [DW-1:0] own_c,
  input  logic [DW-1:0] own_x,
  input  logic          dup_v,
  input  logic [AW-1:0] dup_acc,
  input  logic [DW-1:0] dup_c,
  input  logic [DW-1:0] dup_x,
  output logic [AW-1:0] res
);
  pe_sel_e              sel;
  logic [AW-1:0]        acc;
  logic signed [DW-1:0] c;
  logic signed [DW-1:0] x;
  logic signed [AW-1:0] mul;
  logic [AW-1:0]        sum;

  // Own work wins; the schedule guarantees both never coincide
  always_comb begin
    sel = PE_IDLE;
    if (own_v)      sel = PE_OWN;
    else if (dup_v) sel = PE_DUP;
  end

  always_comb begin
    case (sel)
      PE_OWN: begin
        acc = own_acc;
        c   = own_c;
        x   = own_x;
      end
      PE_DUP: begin
        acc = dup_acc;
        c   = dup_c;
        x   = dup_x;
      end
      default: begin
        acc = '0;
        c   = '0;
        x   = '0;
      end
    endcase
  end

  assign mul = AW'(c) * AW'(x);
  assign sum = acc + $unsigned(mul);

  generate
    if (STUCK_EN) begin : g_stuck
      assign res = sum | (AW'(1) << STUCK_BIT);
    end else begin : g_clean
      assign res = sum;
    end
  endgenerate
endmodule

// File: rtl/sysdup_match.sv
module sysdup_match #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          mis
);
  assign mis = en && (a != b);
endmodule

// File: rtl/sysdup_array.sv
module sysdup_array #(
  parameter int DW        = 16,
  parameter int AW        = 32,
  parameter int BAND      = 3,
  parameter int STUCK_PE  = -1,
  parameter int STUCK_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_first,
  input  logic [BAND*DW-1:0] in_coef,
  input  logic [BAND*DW-1:0] in_x,
  output logic               out_valid,
  output logic               out_first,
  output logic [AW-1:0]      out_y,
  output logic               out_err,
  output logic               err_sticky
);
  localparam int VW  = BAND * DW;
  localparam int NPE = BAND + 1;

  logic took_q;
  logic accept;
  logic err_q;

  // Stage inputs: what element k works on in this cycle
  logic [BAND-1:0]         iv;
  logic [BAND-1:0]         ifirst;
  logic [BAND-1:0]         ierr;
  logic [BAND-1:0]         mis;
  logic [BAND-1:0][AW-1:0] iacc;
  logic [BAND-1:0][VW-1:0] icoef;
  logic [BAND-1:0][VW-1:0] ix;

  // Stage registers between elements
  logic [BAND-1:0]         st_v;
  logic [BAND-1:0]         st_first;
  logic [BAND-1:0]         st_err;
  logic [BAND-1:0][AW-1:0] st_acc;
  logic [BAND-2:0][VW-1:0] st_coef;
  logic [BAND-2:0][VW-1:0] st_x;

  logic [NPE-1:0]          pe_own_v;
  logic [NPE-1:0]          pe_dup_v;
  logic [NPE-1:0][AW-1:0]  pe_res;

  logic                    unused_hi;

  assign in_ready = ~took_q;
  assign accept   = in_valid & ~took_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) took_q <= 1'b0;
    else        took_q <= accept;
  end

  generate
    for (genvar k = 0; k < BAND; k++) begin : g_stage_in
      if (k == 0) begin : g_head
        assign iv[k]     = accept;
        assign iacc[k]   = '0;
        assign icoef[k]  = in_coef;
        assign ix[k]     = in_x;
        assign ifirst[k] = in_first;
        assign ierr[k]   = 1'b0;
      end else begin : g_body
        assign iv[k]     = st_v[k-1];
        assign iacc[k]   = st_acc[k-1];
        assign icoef[k]  = st_coef[k-1];
        assign ix[k]     = st_x[k-1];
        assign ifirst[k] = st_first[k-1];
        assign ierr[k]   = st_err[k-1];
      end
    end
  endgenerate

  // Processing elements 0..BAND-1 plus the spare at index BAND
  generate
    for (genvar k = 0; k < NPE; k++) begin : g_pe
      logic          o_v;
      logic [AW-1:0] o_acc;
      logic [DW-1:0] o_c;
      logic [DW-1:0] o_x;
      logic          d_v;
      logic [AW-1:0] d_acc;
      logic [DW-1:0] d_c;
      logic [DW-1:0] d_x;

      if (k < BAND) begin : g_own
        assign o_v   = iv[k];
        assign o_acc = iacc[k];
        assign o_c   = icoef[k][DW-1:0];
        assign o_x   = ix[k][DW-1:0];
      end else begin : g_no_own
        assign o_v   = 1'b0;
        assign o_acc = '0;
        assign o_c   = '0;
        assign o_x   = '0;
      end

      if (k > 0) begin : g_dup
        assign d_v   = iv[k-1];
        assign d_acc = iacc[k-1];
        assign d_c   = icoef[k-1][DW-1:0];
        assign d_x   = ix[k-1][DW-1:0];
      end else begin : g_no_dup
        assign d_v   = 1'b0;
        assign d_acc = '0;
        assign d_c   = '0;
        assign d_x   = '0;
      end

      assign pe_own_v[k] = o_v;
      assign pe_dup_v[k] = d_v;

      sysdup_pe #(
        .DW       (DW),
        .AW       (AW),
        .STUCK_EN (k == STUCK_PE),
        .STUCK_BIT(STUCK_BIT)
      ) u_pe (
        .own_v  (o_v),
        .own_acc(o_acc),
        .own_c  (o_c),
        .own_x  (o_x),
        .dup_v  (d_v),
        .dup_acc(d_acc),
        .dup_c  (d_c),
        .dup_x  (d_x),
        .res    (pe_res[k])
      );
    end
  endgenerate

  generate
    for (genvar k = 0; k < BAND; k++) begin : g_match
      sysdup_match #(.AW(AW)) u_match (
        .en (iv[k]),
        .a  (pe_res[k]),
        .b  (pe_res[k+1]),
        .mis(mis[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v     <= '0;
      st_first <= '0;
      st_err   <= '0;
      st_acc   <= '0;
    end else begin
      st_v <= iv;
      for (int k = 0; k < BAND; k++) begin
        if (iv[k]) begin
          st_acc[k]   <= pe_res[k];
          st_err[k]   <= ierr[k] | mis[k];
          st_first[k] <= ifirst[k];
        end
      end
    end
  end

  // Operand lanes shift down so each element always reads lane 0
  always_ff @(posedge clk) begin
    for (int k = 0; k < BAND-1; k++) begin
      if (iv[k]) begin
        st_coef[k] <= icoef[k] >> DW;
        st_x[k]    <= ix[k] >> DW;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|mis);
  end

  assign unused_hi  = ^{icoef[BAND-1][VW-1:DW], ix[BAND-1][VW-1:DW]};

  assign out_valid  = st_v[BAND-1];
  assign out_first  = st_first[BAND-1];
  assign out_y      = st_acc[BAND-1];
  assign out_err    = st_err[BAND-1];
  assign err_sticky = err_q;
endmodule

// File: rtl/sysdup_array_chk.sv
module sysdup_array_chk #(
  parameter int BAND = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_err,
  input logic          err_sticky,
  input logic [BAND:0] own_v,
  input logic [BAND:0] dup_v
);
  assert_gap_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_returns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  generate
    for (genvar k = 0; k < BAND; k++) begin : g_alt
      assert_pe_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        own_v[k] |=> !own_v[k]);
    end
  endgenerate

  assert_single_task_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v & dup_v) == '0);

  assert_flag_sets_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> err_sticky);

  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_out_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

bind sysdup_array sysdup_array_chk #(.BAND(BAND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_err   (out_err),
  .err_sticky(err_sticky),
  .own_v     (pe_own_v),
  .dup_v     (pe_dup_v)
);

// File: tb/test_sysdup_array.sv
module test_sysdup_array;
  localparam int CLK_PERIOD = 10;
  localparam int BAND = 3;
  localparam int SB   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic [47:0] in_coef = '0;
  logic [47:0] in_x = '0;

  logic rdy0, rdy1, rdy3;
  logic ov0, ov1, ov3, of0, of1, of3, oe0, oe1, oe3, sk0, sk1, sk3;
  logic [31:0] oy0, oy1, oy3;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sn = 0;
  int on = 0;
  int exp_y [64];
  bit exp_f [64];
  int exp_c [64];
  int got_y0 [64];
  int got_y1 [64];
  int got_y3 [64];
  bit got_e0 [64];
  bit got_e1 [64];
  bit got_e3 [64];
  bit got_f0 [64];
  int got_c [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysdup_array i_sysdup_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_first(in_first), .in_coef(in_coef), .in_x(in_x),
    .out_valid(ov0), .out_first(of0), .out_y(oy0), .out_err(oe0), .err_sticky(sk0));

  sysdup_array #(.STUCK_PE(1), .STUCK_BIT(SB)) i_sysdup_array_f1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_first(in_first), .in_coef(in_coef), .in_x(in_x),
    .out_valid(ov1), .out_first(of1), .out_y(oy1), .out_err(oe1), .err_sticky(sk1));

  sysdup_array #(.STUCK_PE(3), .STUCK_BIT(SB)) i_sysdup_array_f3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy3),
    .in_first(in_first), .in_coef(in_coef), .in_x(in_x),
    .out_valid(ov3), .out_first(of3), .out_y(oy3), .out_err(oe3), .err_sticky(sk3));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (ov0 && on < 64) begin
      got_y0[on] = oy0;
      got_y1[on] = oy1;
      got_y3[on] = oy3;
      got_e0[on] = oe0;
      got_e1[on] = oe1;
      got_e3[on] = oe3;
      got_f0[on] = of0;
      got_c[on]  = cyc;
      on++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [47:0] pack3(input int a0, input int a1, input int a2);
    return {a2[15:0], a1[15:0], a0[15:0]};
  endfunction

  function automatic int dot(input logic [47:0] c, input logic [47:0] x);
    int s = 0;
    for (int k = 0; k < BAND; k++)
      s += int'($signed(c[16*k +: 16])) * int'($signed(x[16*k +: 16]));
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sn = 0;
    on = 0;
  endtask

  task automatic send(input logic [47:0] c, input logic [47:0] x, input bit f);
    @(negedge clk);
    while (!rdy0) @(negedge clk);
    in_valid = 1'b1;
    in_coef  = c;
    in_x     = x;
    in_first = f;
    exp_y[sn] = dot(c, x);
    exp_f[sn] = f;
    exp_c[sn] = cyc + BAND;
    sn++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rdy0 == 1'b1, "R8", "in_ready after reset", rdy0, 1);
    chk(ov0 == 1'b0, "R8", "out_valid after reset", ov0, 0);
    chk(sk0 == 1'b0, "R8", "err_sticky after reset", sk0, 0);
    chk(sk1 == 1'b0, "R8", "faulty copy err_sticky after reset", sk1, 0);
  endtask

  task automatic t_single();
    do_reset();
    send(pack3(3, -2, 5), pack3(7, 11, -4), 1'b1);
    drain();
    chk(on == 1, "R3", "result count", on, 1);
    chk(got_y0[0] == exp_y[0], "R2", "single row value", got_y0[0], exp_y[0]);
    chk(got_f0[0] == 1'b1, "R2", "out_first copy", got_f0[0], 1);
    chk(got_c[0] == exp_c[0], "R3", "result cycle", got_c[0], exp_c[0]);
    chk(got_e0[0] == 1'b0, "R6", "clean flag", got_e0[0], 0);
    chk(got_y3[0] == exp_y[0], "R9", "spare-fault copy value", got_y3[0], exp_y[0]);
  endtask

  task automatic t_patterns();
    do_reset();
    send(pack3(0, 0, 0), pack3(1234, -99, 77), 1'b1);
    send(pack3(-32768, -32768, -32768), pack3(-32768, -32768, -32768), 1'b0);
    send(pack3(32767, -32768, 1), pack3(-32768, 32767, -1), 1'b0);
    send(pack3(-1, 2, -3), pack3(4, -5, 6), 1'b1);
    drain();
    chk(on == sn, "R3", "pattern result count", on, sn);
    for (int i = 0; i < sn; i++) begin
      chk(got_y0[i] == exp_y[i], "R2", $sformatf("pattern %0d value", i), got_y0[i], exp_y[i]);
      chk(got_f0[i] == exp_f[i], "R2", $sformatf("pattern %0d first", i), got_f0[i], exp_f[i]);
      chk(got_e0[i] == 1'b0, "R6", $sformatf("pattern %0d flag", i), got_e0[i], 0);
      chk(got_y3[i] == exp_y[i], "R9", $sformatf("pattern %0d spare-fault value", i), got_y3[i], exp_y[i]);
    end
  endtask

  task automatic t_stream();
    int j = 0;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(rdy0 == ((i % 2) == 0), "R1", $sformatf("ready in held-valid cycle %0d", i), rdy0, (i % 2) == 0);
      in_valid = 1'b1;
      if (rdy0) begin
        in_coef  = pack3(j + 1, -3 * j, 100 - j);
        in_x     = pack3(-7 * j, j + 2, 5 * j - 9);
        in_first = (j == 0);
        exp_y[sn] = dot(in_coef, in_x);
        exp_f[sn] = (j == 0);
        exp_c[sn] = cyc + BAND;
        sn++;
        j++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk(sn == 6, "R3", "beats accepted in 12 held cycles", sn, 6);
    chk(on == sn, "R3", "stream result count", on, sn);
    for (int i = 0; i < sn; i++) begin
      chk(got_y0[i] == exp_y[i], "R2", $sformatf("stream %0d value", i), got_y0[i], exp_y[i]);
      chk(got_c[i] == exp_c[i], "R3", $sformatf("stream %0d cycle", i), got_c[i], exp_c[i]);
      chk(got_e0[i] == 1'b0, "R4", $sformatf("stream %0d flag at full rate", i), got_e0[i], 0);
      if (i > 0)
        chk(got_c[i] - got_c[i-1] == 2, "R10", $sformatf("stream %0d spacing", i),
            got_c[i] - got_c[i-1], 2);
    end
    chk(sk0 == 1'b0, "R6", "clean sticky after stream", sk0, 0);
  endtask

  task automatic t_fault();
    do_reset();
    chk(sk1 == 1'b0, "R8", "faulty sticky before work", sk1, 0);
    send(pack3(10, 20, 30), pack3(100, 200, 300), 1'b1);
    send(pack3(1, 2, 3), pack3(4, 5, 6), 1'b0);
    drain();
    chk(on == 2, "R3", "fault run result count", on, 2);
    for (int i = 0; i < 2; i++) begin
      chk(got_e1[i] == 1'b1, "R5", $sformatf("middle fault flag %0d", i), got_e1[i], 1);
      chk(got_y1[i] == exp_y[i] + (1 << SB), "R5", $sformatf("middle fault value %0d", i),
          got_y1[i], exp_y[i] + (1 << SB));
      chk(got_e3[i] == 1'b1, "R9", $sformatf("spare fault flag %0d", i), got_e3[i], 1);
      chk(got_y3[i] == exp_y[i], "R9", $sformatf("spare fault value %0d", i), got_y3[i], exp_y[i]);
      chk(got_e0[i] == 1'b0, "R6", $sformatf("clean flag %0d", i), got_e0[i], 0);
    end
    chk(sk1 == 1'b1, "R7", "sticky set", sk1, 1);
    repeat (10) @(negedge clk);
    chk(sk1 == 1'b1, "R7", "sticky held through idle", sk1, 1);
    chk(sk3 == 1'b1, "R7", "spare-fault sticky held", sk3, 1);
    chk(sk0 == 1'b0, "R6", "clean sticky", sk0, 0);
    do_reset();
    chk(sk1 == 1'b0, "R7", "sticky cleared by reset", sk1, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_patterns();
    t_stream();
    t_fault();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule